// File: doc/BRIEF.md
# Serial Configuration Register File for a Dual H-Bridge Actuator Controller

This block takes write-only configuration frames from a host over a three-wire serial link. The three wires are a shift clock, a data line and a latch strobe. Each frame holds sixteen bits. The block places each frame into one of sixteen configuration registers. The decoded fields drive the settings of a two-channel actuator controller:

- PWM duty codes
- hall-sensor bias and offset DAC codes
- hall amplifier gain and offset-ratio selects
- general-purpose amplifier enables
- PWM resolution select
- pulse-step counts
- clock-source select

The block has no readback path.

All three serial wires are resynchronized into the system clock domain and edge-detected there. The standby pin goes through the same synchronizer. The system clock must run at least four times faster than the 4 MHz maximum shift clock.

A four-state machine tracks each frame:

- **IDLE**: no bits have been received.
- **SHIFT**: between one and fifteen bits have been received.
- **FULL**: sixteen bits have been received and the frame is waiting for the strobe.
- **HOLD**: the strobe is high.

The transitions are:

- *first bit*: IDLE to SHIFT.
- *sixteenth bit*: SHIFT to FULL.
- *strobe rise*: IDLE, SHIFT or FULL to HOLD. The frame is committed only when the strobe rises in FULL.
- *strobe low*: HOLD to IDLE.
- *strobe high in IDLE* (for example, the strobe is already high when reset ends): IDLE to HOLD.
- *standby*: any state to IDLE.

Top module: `cfg_serial_regfile`

## Requirements
- R1: After reset, every output is 0, which includes clock-source select 0 (external clock).
- R2: Bit order and commit. A frame is 4 address bits followed by 12 data bits. Each field is sent least significant bit first. The frame is written to the addressed register only when the strobe rises after exactly sixteen bits.
- R3: The data of each address drives these outputs (data bits are numbered D0..D11):

  | Address | Output |
  |---|---|
  | 0 | duty_code[0], D11..D0 |
  | 1 | duty_code[1], D11..D0 |
  | 2 | hall_bias[0], D7..D0 |
  | 3 | hall_bias[1], D7..D0 |
  | 4 | hall_ofs_dac[0], D7..D0 |
  | 5 | hall_ofs_dac[1], D7..D0 |
  | 8 | gain_sel[0], D3..D0 |
  | 9 | gain_sel[1], D3..D0 |
  | 10 | ratio_sel[0], D3..D0 |
  | 11 | ratio_sel[1], D3..D0 |
  | 14 | step_cnt[0] from D3..D0; step_cnt[1] from D7..D4 |

- R4: Address 12 sets amp_en. amp_en[0] takes D0 and amp_en[1] takes D1. A value of 1 means the amplifier operates.
- R5: Address 13 sets pwm_res from D1..D0. The codes are 00 for 10 bits, 01 for 11 bits and 10 for 12 bits. Address 15 sets int_clk_sel from D0, where 1 selects the internal clock.
- R6: If the strobe rises after fewer than sixteen bits, the frame is discarded and the bit counter clears. A complete frame that follows is stored correctly.
- R7: Shift-clock edges that occur while the strobe is high shift nothing.
- R8: Bits beyond the sixteenth, before the strobe, are ignored.
- R9: While stdby_n is low, all registers, including the clock-source select, are held at their reset values and incoming frames have no effect.
- R10: A frame addressed to 6 or 7 changes no output.
- R11: Outputs change only on a commit or a clear. Shifting a frame without a strobe leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stdby_n | input | 1 | Standby pin; low clears all registers |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_lat | input | 1 | Latch strobe; its rising edge commits the frame |
| duty_code | output | 2x12 | PWM duty code per channel |
| hall_bias | output | 2x8 | Hall bias DAC code per channel |
| hall_ofs_dac | output | 2x8 | Hall offset DAC code per channel |
| gain_sel | output | 2x4 | Hall amplifier gain select per channel |
| ratio_sel | output | 2x4 | Hall amplifier offset-ratio select per channel |
| amp_en | output | 2 | General-purpose amplifier enables |
| pwm_res | output | 2 | PWM resolution select |
| step_cnt | output | 2x4 | Pulse-step count per channel |
| int_clk_sel | output | 1 | 1 = internal clock, 0 = external clock |

## Verification
The assertions check the following on every cycle:

- No shift happens while the strobe is high.
- A commit happens only after the checker's own count reaches sixteen shifts since the last strobe or clear.
- The register bank holds steady unless a commit or a clear occurs.
- Commits to addresses 6 and 7 leave the bank untouched.
- A clear returns the bank and the clock-source select to zero.

The directed scenarios show the things a cycle-level property cannot:

- LSB-first bit ordering and the mapping of fields to ports.
- Recovery after a short frame.
- Immunity to shift clocks during the strobe.
- The discarding of surplus bits.
- Behaviour across a standby interval.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 12;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int NREG    = 1 << ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam int NCH     = 2;
    localparam int DUTY_W  = 12;
    localparam int DAC_W   = 8;
    localparam int SEL_W   = 4;
    localparam int RES_W   = 2;
    localparam int STEP_W  = 4;

    // register addresses that carry behaviour
    localparam logic [ADDR_W-1:0] A_DUTY0  = 4'd0;
    localparam logic [ADDR_W-1:0] A_BIAS0  = 4'd2;
    localparam logic [ADDR_W-1:0] A_OFS0   = 4'd4;
    localparam logic [ADDR_W-1:0] A_GAP0   = 4'd6;
    localparam logic [ADDR_W-1:0] A_GAP1   = 4'd7;
    localparam logic [ADDR_W-1:0] A_GAIN0  = 4'd8;
    localparam logic [ADDR_W-1:0] A_RATIO0 = 4'd10;
    localparam logic [ADDR_W-1:0] A_AMP    = 4'd12;
    localparam logic [ADDR_W-1:0] A_RES    = 4'd13;
    localparam logic [ADDR_W-1:0] A_STEP   = 4'd14;
    localparam logic [ADDR_W-1:0] A_CLKSRC = 4'd15;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2,
        ST_HOLD  = 2'd3
    } frame_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // bits of each register that hold state; the rest read as zero
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        logic [DATA_W-1:0] m;
        unique case (idx)
            0, 1:         m = {DATA_W{1'b1}};
            2, 3, 4, 5:   m = DATA_W'((1 << DAC_W) - 1);
            8, 9, 10, 11: m = DATA_W'((1 << SEL_W) - 1);
            12, 13:       m = DATA_W'(3);
            14:           m = DATA_W'((1 << (2 * STEP_W)) - 1);
            15:           m = DATA_W'(1);
            default:      m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgsr_sync.sv
module cfgsr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                    prev  <= 1'b0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[b]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign lvl[b]  = chain[STAGES-1];
            assign rise[b] = chain[STAGES-1] & ~prev;
        end
    endgenerate

endmodule

// File: rtl/cfgsr_shifter.sv
module cfgsr_shifter
    import cfgsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   sclk_rise,
    input  logic   dat_lvl,
    input  logic   stb_lvl,
    input  logic   stb_rise,
    output logic   shift_en,
    output logic   commit,
    output frame_t frame
);

    frame_state_e       state_q, state_d;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               last_bit;

    assign last_bit = (cnt_q == CNT_W'(FRAME_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else if (stb_rise) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (stb_lvl)        state_d = ST_HOLD;
                          else if (sclk_rise) state_d = ST_SHIFT;
                ST_SHIFT: if (sclk_rise && last_bit) state_d = ST_FULL;
                ST_FULL:  state_d = ST_FULL;
                ST_HOLD:  if (!stb_lvl)       state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs of the machine
    always_comb begin
        shift_en = 1'b0;
        commit   = 1'b0;
        if (!clr) begin
            unique case (state_q)
                ST_IDLE, ST_SHIFT: shift_en = sclk_rise && !stb_lvl;
                ST_FULL:           commit   = stb_rise;
                ST_HOLD:           ;
                default:           ;
            endcase
        end
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (clr || stb_rise) begin
            cnt_q   <= '0;
        end else if (shift_en) begin
            shreg_q <= {dat_lvl, shreg_q[FRAME_W-1:1]};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // first bit shifted in ends in bit 0: address low, data above
    assign frame.addr = shreg_q[ADDR_W-1:0];
    assign frame.data = shreg_q[FRAME_W-1:ADDR_W];

endmodule

// File: rtl/cfgsr_regs.sv
module cfgsr_regs
    import cfgsr_pkg::*;
#(
    parameter logic CLKSRC_RST = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   commit,
    input  frame_t                 frame,
    output logic [NREG*DATA_W-1:0] bank
);

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            localparam logic [DATA_W-1:0] MASK = reg_mask(i);
            localparam logic [DATA_W-1:0] RSTV =
                (i == int'(A_CLKSRC)) ? DATA_W'(CLKSRC_RST) : '0;
            logic [DATA_W-1:0] q;
            logic              we;

            assign we = commit && (frame.addr == ADDR_W'(i)) && (MASK != '0);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= RSTV;
                else if (clr) q <= RSTV;
                else if (we)  q <= frame.data & MASK;
            end

            assign bank[i*DATA_W +: DATA_W] = q;
        end
    endgenerate

endmodule

// File: rtl/cfg_serial_regfile.sv
module cfg_serial_regfile
    import cfgsr_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic CLKSRC_RST  = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         stdby_n,
    input  logic                         ser_clk,
    input  logic                         ser_dat,
    input  logic                         ser_lat,
    output logic [NCH-1:0][DUTY_W-1:0]   duty_code,
    output logic [NCH-1:0][DAC_W-1:0]    hall_bias,
    output logic [NCH-1:0][DAC_W-1:0]    hall_ofs_dac,
    output logic [NCH-1:0][SEL_W-1:0]    gain_sel,
    output logic [NCH-1:0][SEL_W-1:0]    ratio_sel,
    output logic [NCH-1:0]               amp_en,
    output logic [RES_W-1:0]             pwm_res,
    output logic [NCH-1:0][STEP_W-1:0]   step_cnt,
    output logic                         int_clk_sel
);

    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_STB = 2;
    localparam int IDX_SBY = 3;

    logic [3:0]             s_lvl, s_rise;
    logic                   clr, shift_en, commit;
    frame_t                 frame;
    logic [NREG*DATA_W-1:0] bank;

    cfgsr_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({stdby_n, ser_lat, ser_dat, ser_clk}),
        .lvl      (s_lvl),
        .rise     (s_rise)
    );

    assign clr = ~s_lvl[IDX_SBY];

    cfgsr_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sclk_rise (s_rise[IDX_CLK]),
        .dat_lvl   (s_lvl[IDX_DAT]),
        .stb_lvl   (s_lvl[IDX_STB]),
        .stb_rise  (s_rise[IDX_STB]),
        .shift_en  (shift_en),
        .commit    (commit),
        .frame     (frame)
    );

    cfgsr_regs #(.CLKSRC_RST(CLKSRC_RST)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .commit (commit),
        .frame  (frame),
        .bank   (bank)
    );

    function automatic logic [DATA_W-1:0] rd(input logic [ADDR_W-1:0] a);
        return bank[int'(a)*DATA_W +: DATA_W];
    endfunction

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign duty_code[c]    = rd(A_DUTY0  + ADDR_W'(c))[DUTY_W-1:0];
            assign hall_bias[c]    = rd(A_BIAS0  + ADDR_W'(c))[DAC_W-1:0];
            assign hall_ofs_dac[c] = rd(A_OFS0   + ADDR_W'(c))[DAC_W-1:0];
            assign gain_sel[c]     = rd(A_GAIN0  + ADDR_W'(c))[SEL_W-1:0];
            assign ratio_sel[c]    = rd(A_RATIO0 + ADDR_W'(c))[SEL_W-1:0];
            assign step_cnt[c]     = rd(A_STEP)[c*STEP_W +: STEP_W];
            assign amp_en[c]       = rd(A_AMP)[c];
        end
    endgenerate

    assign pwm_res     = rd(A_RES)[RES_W-1:0];
    assign int_clk_sel = rd(A_CLKSRC)[0];

endmodule

// File: rtl/cfgsr_chk.sv
module cfgsr_chk
    import cfgsr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr,
    input logic                   shift_en,
    input logic                   commit,
    input logic                   stb_lvl,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [NREG*DATA_W-1:0] bank
);

    // independent count of shifts since the last strobe or clear
    logic [CNT_W-1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  seen <= '0;
        else if (clr || stb_lvl)                     seen <= '0;
        else if (shift_en && seen < CNT_W'(FRAME_W)) seen <= seen + 1'b1;
    end

    // R7
    stb_blocks_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_lvl |-> !shift_en);

    // R6
    commit_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> seen == CNT_W'(FRAME_W));

    // R11
    bank_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clr) |=> $stable(bank));

    // R10
    gap_addr_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !clr && (wr_addr == A_GAP0 || wr_addr == A_GAP1)) |=> $stable(bank));

    // R9
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> bank == '0);

    // R5
    standby_extclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> bank[int'(A_CLKSRC)*DATA_W] == 1'b0);

endmodule

bind cfg_serial_regfile cfgsr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift_en (shift_en),
    .commit   (commit),
    .stb_lvl  (s_lvl[2]),
    .wr_addr  (frame.addr),
    .bank     (bank)
);

// File: tb/tb_cfg_serial_regfile.sv
module tb_cfg_serial_regfile;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stdby_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;

    logic [1:0][11:0] duty_code;
    logic [1:0][7:0]  hall_bias, hall_ofs_dac;
    logic [1:0][3:0]  gain_sel, ratio_sel, step_cnt;
    logic [1:0]       amp_en, pwm_res;
    logic             int_clk_sel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_serial_regfile dut (
        .clk(clk), .rst_n(rst_n), .stdby_n(stdby_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
        .duty_code(duty_code), .hall_bias(hall_bias), .hall_ofs_dac(hall_ofs_dac),
        .gain_sel(gain_sel), .ratio_sel(ratio_sel), .amp_en(amp_en),
        .pwm_res(pwm_res), .step_cnt(step_cnt), .int_clk_sel(int_clk_sel)
    );

    wire [84:0] allout = {duty_code, hall_bias, hall_ofs_dac, gain_sel,
                          ratio_sel, amp_en, pwm_res, step_cnt, int_clk_sel};

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
    endtask

    task automatic send_bits(input int n, input logic [15:0] v);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic strobe();
        wait_clk(2);
        ser_lat = 1'b1;
        wait_clk(6);
        ser_lat = 1'b0;
        wait_clk(6);
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [11:0] d);
        send_bits(16, {d, a});
        strobe();
    endtask

    task automatic t_reset();
        check("R1 all outputs zero", 96'(allout), 96'(0));
        check("R1 external clock", 96'(int_clk_sel), 96'(0));
    endtask

    task automatic t_map();
        write_reg(4'd0, 12'hA5C);
        write_reg(4'd1, 12'h3F1);
        check("R2 duty ch1", 96'(duty_code[0]), 96'h A5C);
        check("R2 duty ch2", 96'(duty_code[1]), 96'h3F1);
        write_reg(4'd2, 12'h05A);
        write_reg(4'd3, 12'h9C3);
        write_reg(4'd4, 12'h011);
        write_reg(4'd5, 12'hFFE);
        check("R3 bias ch1", 96'(hall_bias[0]), 96'h5A);
        check("R3 bias ch2", 96'(hall_bias[1]), 96'hC3);
        check("R3 ofs dac ch1", 96'(hall_ofs_dac[0]), 96'h11);
        check("R3 ofs dac ch2", 96'(hall_ofs_dac[1]), 96'hFE);
        write_reg(4'd8, 12'h0F3);
        write_reg(4'd9, 12'h00C);
        write_reg(4'd10, 12'h007);
        write_reg(4'd11, 12'h109);
        check("R3 gain ch1", 96'(gain_sel[0]), 96'h3);
        check("R3 gain ch2", 96'(gain_sel[1]), 96'hC);
        check("R3 ratio ch1", 96'(ratio_sel[0]), 96'h7);
        check("R3 ratio ch2", 96'(ratio_sel[1]), 96'h9);
        write_reg(4'd14, 12'h0B5);
        check("R3 step ch1", 96'(step_cnt[0]), 96'h5);
        check("R3 step ch2", 96'(step_cnt[1]), 96'hB);
    endtask

    task automatic t_ctrl();
        write_reg(4'd12, 12'h002);
        check("R4 amp enables", 96'(amp_en), 96'b10);
        write_reg(4'd12, 12'h001);
        check("R4 amp enables", 96'(amp_en), 96'b01);
        write_reg(4'd13, 12'h002);
        check("R5 pwm resolution 12-bit", 96'(pwm_res), 96'b10);
        write_reg(4'd15, 12'h001);
        check("R5 internal clock", 96'(int_clk_sel), 96'(1));
    endtask

    task automatic t_short();
        logic [84:0] snap;
        snap = allout;
        send_bits(10, 16'hFFF1);
        strobe();
        check("R6 short frame discarded", 96'(allout), 96'(snap));
        write_reg(4'd1, 12'h123);
        check("R6 full frame after short", 96'(duty_code[1]), 96'h123);
    endtask

    task automatic t_stb_high();
        send_bits(16, {12'h456, 4'd0});
        wait_clk(2);
        ser_lat = 1'b1;
        wait_clk(6);
        check("R2 commit on strobe", 96'(duty_code[0]), 96'h456);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        ser_lat = 1'b0;
        wait_clk(6);
        write_reg(4'd0, 12'h789);
        check("R7 shift clock ignored under strobe", 96'(duty_code[0]), 96'h789);
    endtask

    task automatic t_extra();
        logic [84:0] snap;
        send_bits(16, {12'h006, 4'd9});
        send_bits(4, 16'h000F);
        snap = allout;
        wait_clk(6);
        check("R11 no change before strobe", 96'(allout), 96'(snap));
        strobe();
        check("R8 extra bits ignored", 96'(gain_sel[1]), 96'h6);
    endtask

    task automatic t_gap();
        logic [84:0] snap;
        snap = allout;
        write_reg(4'd6, 12'hFFF);
        write_reg(4'd7, 12'hFFF);
        check("R10 addresses 6 and 7 inert", 96'(allout), 96'(snap));
    endtask

    task automatic t_standby();
        stdby_n = 1'b0;
        wait_clk(6);
        check("R9 standby clears", 96'(allout), 96'(0));
        check("R9 standby external clock", 96'(int_clk_sel), 96'(0));
        write_reg(4'd0, 12'hABC);
        check("R9 writes ignored in standby", 96'(allout), 96'(0));
        stdby_n = 1'b1;
        wait_clk(6);
        check("R9 registers stay clear on resume", 96'(allout), 96'(0));
        write_reg(4'd2, 12'h077);
        check("R9 operation resumes", 96'(hall_bias[0]), 96'h77);
    endtask

    initial begin
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        stdby_n = 1'b1;
        wait_clk(6);
        t_reset();
        t_map();
        t_ctrl();
        t_short();
        t_stb_high();
        t_extra();
        t_gap();
        t_standby();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule